// File: doc/BRIEF.md
# Accumulator-Pair Multiply/Divide Unit

This block carries out integer multiplication and division on operands held in an accumulator register and a companion high-half register. It handles two operand sizes. In the narrow form, the low half of the accumulator is multiplied by the source, or the full accumulator is divided by the source. In the wide form, the full accumulator is multiplied by the source, or the high register and the accumulator together form a double-width dividend. Each operation runs as unsigned or as two's-complement signed.

A one-cycle start strobe latches the operands and the mode. The block then steps through one bit of the source per cycle. Multiplication uses shift-and-add. Division uses the restoring method on magnitudes, and the signs are fixed up at the end.

When the operation finishes, the block presents the new accumulator and high-register values and pulses `done` for one cycle. A multiply also reports whether the upper half of the product carries information. A division by zero, or a quotient too large for its destination half, raises `div_err` and returns both registers unchanged.

Top module: `muldiv_unit`

## Requirements
- R1: With `op_wide`=0 and `op_div`=0, `acc_out` receives the 16-bit product of `acc_in[7:0]` and `src_in[7:0]`, and `hi_out` equals `hi_in`.
- R2: With `op_wide`=1 and `op_div`=0, the 32-bit product of `acc_in` and `src_in` appears as {`hi_out`,`acc_out`}, with the upper half in `hi_out`.
- R3: With `op_wide`=0 and `op_div`=1, `acc_in` is divided by `src_in[7:0]`. The quotient goes to `acc_out[7:0]`, the remainder goes to `acc_out[15:8]`, and `hi_out` equals `hi_in`.
- R4: With `op_wide`=1 and `op_div`=1, the dividend {`hi_in`,`acc_in`} is divided by `src_in`. The quotient goes to `acc_out` and the remainder goes to `hi_out`.
- R5: With `op_signed`=1, operands are two's complement, the quotient truncates toward zero, and a nonzero remainder has the sign of the dividend.
- R6: A divide with a zero divisor, or with a quotient outside the destination half's range (0..2^N-1 unsigned, -2^(N-1)..2^(N-1)-1 signed), raises `div_err` together with `done` and leaves `acc_out`=`acc_in` and `hi_out`=`hi_in`.
- R7: After a multiply, `cf_of` is 1 exactly when the upper half of the product is significant: nonzero for unsigned, or not a sign extension of the lower half for signed. After any divide, `cf_of` is 0.
- R8: `busy` is high from the cycle after `start` is accepted. `done` is a one-cycle pulse, with `busy` low, appearing N+1 clock edges after the accepting edge (N=8 narrow, N=16 wide). The outputs change only together with `done`.
- R9: A `start` pulse while `busy` is high is ignored. The running operation completes with its own operands and produces a single `done`.
- R10: During and after reset, `acc_out`, `hi_out`, `cf_of`, `done`, `div_err` and `busy` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| op_div | input | 1 | 1 = divide, 0 = multiply |
| op_signed | input | 1 | 1 = two's-complement operands |
| op_wide | input | 1 | 1 = 16-bit form, 0 = 8-bit form |
| acc_in | input | 16 | Current accumulator value |
| hi_in | input | 16 | Current high-half register value |
| src_in | input | 16 | Source operand (low byte used in 8-bit form) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| div_err | output | 1 | Divide error, valid with done |
| acc_out | output | 16 | New accumulator value |
| hi_out | output | 16 | New high-half register value |
| cf_of | output | 1 | Product upper half significant |

## Verification
The assertions that compare the error outcome with `acc_in`/`hi_in`, and the one that ties the flag to `op_div`, assume the requester holds the mode and register inputs steady from `start` until the `done` cycle. That is the situation in which the register file feeds the block. The stimulus changes these inputs only after `done` has been seen, plus one further cycle. The single exception is the ignored-start test: there the interfering values are restored before completion, and the restored values are those of the running operation.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WRAP = 2'd2
  } mdu_state_e;
endpackage

// File: rtl/muldiv_operand_prep.sv
module muldiv_operand_prep #(
  parameter int W = 16
) (
  input  logic         is_div,
  input  logic         is_signed,
  input  logic         wide,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] hi_in,
  input  logic [W-1:0] src_in,
  output logic [W-1:0] op_x,
  output logic [W-1:0] op_hi,
  output logic [W-1:0] op_lo,
  output logic         neg_main,
  output logic         neg_rem
);
  localparam int H  = W / 2;
  localparam int DW = 2 * W;

  logic [W-1:0]  nmask, a_raw, b_raw, a_mag, b_mag;
  logic          a_neg, b_neg, d_neg;
  logic [DW-1:0] dmask, d_raw, d_mag;

  always_comb begin
    nmask = wide ? {W{1'b1}} : {{H{1'b0}}, {H{1'b1}}};
    a_raw = acc_in & nmask;
    b_raw = src_in & nmask;
    a_neg = is_signed & (wide ? acc_in[W-1] : acc_in[H-1]);
    b_neg = is_signed & (wide ? src_in[W-1] : src_in[H-1]);
    a_mag = a_neg ? ((~a_raw + W'(1)) & nmask) : a_raw;
    b_mag = b_neg ? ((~b_raw + W'(1)) & nmask) : b_raw;

    dmask = wide ? {DW{1'b1}} : {{W{1'b0}}, {W{1'b1}}};
    d_raw = wide ? {hi_in, acc_in} : {{W{1'b0}}, acc_in};
    d_neg = is_signed & (wide ? hi_in[W-1] : acc_in[W-1]);
    d_mag = d_neg ? ((~d_raw + DW'(1)) & dmask) : d_raw;

    if (is_div) begin
      op_x     = b_mag;
      op_hi    = wide ? d_mag[DW-1:W] : {{H{1'b0}}, d_mag[W-1:H]};
      op_lo    = wide ? d_mag[W-1:0]  : {{H{1'b0}}, d_mag[H-1:0]};
      neg_main = d_neg ^ b_neg;
    end else begin
      op_x     = a_mag;
      op_hi    = '0;
      op_lo    = b_mag;
      neg_main = a_neg ^ b_neg;
    end
    neg_rem = d_neg & is_div;
  end
endmodule

// File: rtl/muldiv_iter_core.sv
module muldiv_iter_core #(
  parameter int W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            step,
  input  logic            is_div,
  input  logic            wide,
  input  logic [W-1:0]    op_x,
  input  logic [W-1:0]    op_hi,
  input  logic [W-1:0]    op_lo,
  output logic [2*W-1:0]  prod,
  output logic [W-1:0]    quo,
  output logic [W-1:0]    rem
);
  localparam int H  = W / 2;
  localparam int DW = 2 * W;

  logic [W-1:0]  x_q, x_d, rem_q, rem_d, sh_q, sh_d, diff;
  logic [DW-1:0] prod_q, prod_d;
  logic [W:0]    trial;
  logic          fits;

  always_comb begin
    x_d    = x_q;
    rem_d  = rem_q;
    sh_d   = sh_q;
    prod_d = prod_q;
    trial  = {rem_q, sh_q[W-1]};
    diff   = trial[W-1:0] - x_q;
    fits   = (trial >= {1'b0, x_q});
    if (load) begin
      x_d    = op_x;
      rem_d  = op_hi;
      prod_d = '0;
      sh_d   = wide ? op_lo : (op_lo << H);
    end else if (step) begin
      if (is_div) begin
        rem_d = fits ? diff : trial[W-1:0];
        sh_d  = {sh_q[W-2:0], fits};
      end else begin
        prod_d = (prod_q << 1) + (sh_q[W-1] ? {{W{1'b0}}, x_q} : {DW{1'b0}});
        sh_d   = {sh_q[W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q    <= '0;
      rem_q  <= '0;
      sh_q   <= '0;
      prod_q <= '0;
    end else if (load || step) begin
      x_q    <= x_d;
      rem_q  <= rem_d;
      sh_q   <= sh_d;
      prod_q <= prod_d;
    end
  end

  assign prod = prod_q;
  assign quo  = sh_q;
  assign rem  = rem_q;
endmodule

// File: rtl/muldiv_result_fix.sv
module muldiv_result_fix #(
  parameter int W = 16
) (
  input  logic           is_div,
  input  logic           is_signed,
  input  logic           wide,
  input  logic           neg_main,
  input  logic           neg_rem,
  input  logic           early_err,
  input  logic [2*W-1:0] prod,
  input  logic [W-1:0]   quo,
  input  logic [W-1:0]   rem,
  input  logic [W-1:0]   acc_keep,
  input  logic [W-1:0]   hi_keep,
  output logic [W-1:0]   acc_res,
  output logic [W-1:0]   hi_res,
  output logic           flag_res,
  output logic           err_res
);
  localparam int H  = W / 2;
  localparam int DW = 2 * W;

  logic [DW-1:0] pmask, ps;
  logic [W-1:0]  qm, qs, rs, lim;
  logic          sig_ovf;

  always_comb begin
    pmask   = wide ? {DW{1'b1}} : {{W{1'b0}}, {W{1'b1}}};
    ps      = neg_main ? ((~prod + DW'(1)) & pmask) : prod;
    qm      = wide ? quo : {{H{1'b0}}, quo[H-1:0]};
    lim     = wide ? (W'(1) << (W - 1)) : (W'(1) << (H - 1));
    sig_ovf = is_signed & (neg_main ? (qm > lim) : (qm >= lim));
    qs      = neg_main ? (~qm + W'(1)) : qm;
    rs      = neg_rem ? (~rem + W'(1)) : rem;
    err_res = 1'b0;
    flag_res = 1'b0;
    if (is_div) begin
      err_res = early_err | sig_ovf;
      if (err_res) begin
        acc_res = acc_keep;
        hi_res  = hi_keep;
      end else if (wide) begin
        acc_res = qs;
        hi_res  = rs;
      end else begin
        acc_res = {rs[H-1:0], qs[H-1:0]};
        hi_res  = hi_keep;
      end
    end else if (wide) begin
      acc_res  = ps[W-1:0];
      hi_res   = ps[DW-1:W];
      flag_res = is_signed ? (ps[DW-1:W] != {W{ps[W-1]}}) : (ps[DW-1:W] != '0);
    end else begin
      acc_res  = ps[W-1:0];
      hi_res   = hi_keep;
      flag_res = is_signed ? (ps[W-1:H] != {H{ps[H-1]}}) : (ps[W-1:H] != '0);
    end
  end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         op_div,
  input  logic         op_signed,
  input  logic         op_wide,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] hi_in,
  input  logic [W-1:0] src_in,
  output logic         busy,
  output logic         done,
  output logic         div_err,
  output logic [W-1:0] acc_out,
  output logic [W-1:0] hi_out,
  output logic         cf_of
);
  import muldiv_pkg::*;
  localparam int H  = W / 2;
  localparam int CW = $clog2(W + 1);

  mdu_state_e     state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           load, step, fin;
  logic           div_q, sgn_q, wide_q, negm_q, negr_q, early_q;
  logic [W-1:0]   acck_q, hik_q;
  logic [W-1:0]   p_x, p_hi, p_lo;
  logic           p_negm, p_negr;
  logic [2*W-1:0] c_prod;
  logic [W-1:0]   c_quo, c_rem;
  logic [W-1:0]   r_acc, r_hi;
  logic           r_flag, r_err;
  logic           done_q, err_q, flag_q;
  logic [W-1:0]   acc_q, hi_q;

  assign load = (state_q == ST_IDLE) && start;
  assign step = (state_q == ST_RUN);
  assign fin  = (state_q == ST_WRAP);

  muldiv_operand_prep #(.W(W)) u_prep (
    .is_div(op_div), .is_signed(op_signed), .wide(op_wide),
    .acc_in(acc_in), .hi_in(hi_in), .src_in(src_in),
    .op_x(p_x), .op_hi(p_hi), .op_lo(p_lo),
    .neg_main(p_negm), .neg_rem(p_negr)
  );

  muldiv_iter_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .is_div(div_q), .wide(op_wide),
    .op_x(p_x), .op_hi(p_hi), .op_lo(p_lo),
    .prod(c_prod), .quo(c_quo), .rem(c_rem)
  );

  muldiv_result_fix #(.W(W)) u_fix (
    .is_div(div_q), .is_signed(sgn_q), .wide(wide_q),
    .neg_main(negm_q), .neg_rem(negr_q), .early_err(early_q),
    .prod(c_prod), .quo(c_quo), .rem(c_rem),
    .acc_keep(acck_q), .hi_keep(hik_q),
    .acc_res(r_acc), .hi_res(r_hi), .flag_res(r_flag), .err_res(r_err)
  );

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: if (load) begin
        state_d = ST_RUN;
        cnt_d   = op_wide ? CW'(W) : CW'(H);
      end
      ST_RUN: begin
        cnt_d = cnt_q - CW'(1);
        if (cnt_q == CW'(1)) state_d = ST_WRAP;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= 1'b0; sgn_q <= 1'b0; wide_q <= 1'b0;
      negm_q <= 1'b0; negr_q <= 1'b0; early_q <= 1'b0;
      acck_q <= '0; hik_q <= '0;
    end else if (load) begin
      div_q   <= op_div;
      sgn_q   <= op_signed;
      wide_q  <= op_wide;
      negm_q  <= p_negm;
      negr_q  <= p_negr;
      early_q <= op_div & (p_hi >= p_x);
      acck_q  <= acc_in;
      hik_q   <= hi_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      flag_q <= 1'b0;
      acc_q  <= '0;
      hi_q   <= '0;
    end else begin
      done_q <= fin;
      err_q  <= fin & r_err;
      if (fin) begin
        acc_q  <= r_acc;
        hi_q   <= r_hi;
        flag_q <= r_flag;
      end
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;
  assign div_err = err_q;
  assign acc_out = acc_q;
  assign hi_out  = hi_q;
  assign cf_of   = flag_q;
endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_div,
  input logic         op_wide,
  input logic [W-1:0] acc_in,
  input logic [W-1:0] hi_in,
  input logic         busy,
  input logic         done,
  input logic         div_err,
  input logic [W-1:0] acc_out,
  input logic [W-1:0] hi_out,
  input logic         cf_of
);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({acc_out, hi_out, cf_of}) |-> done);
  // R6
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_err |-> done);
  // R6
  err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_err |-> (acc_out == acc_in && hi_out == hi_in));
  // R7
  div_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_div) |-> !cf_of);
  // R1
  narrow_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !op_div && !op_wide) |-> (hi_out == hi_in));
endmodule

bind muldiv_unit muldiv_unit_chk #(.W(W)) u_chk (.*);

// File: tb/tb_muldiv_unit.sv
module tb_muldiv_unit;
  localparam int W = 16;
  logic clk = 1'b0;
  logic rst_n, start, op_div, op_signed, op_wide;
  logic [W-1:0] acc_in, hi_in, src_in;
  logic busy, done, div_err, cf_of;
  logic [W-1:0] acc_out, hi_out;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  muldiv_unit #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_div(op_div),
    .op_signed(op_signed), .op_wide(op_wide), .acc_in(acc_in),
    .hi_in(hi_in), .src_in(src_in), .busy(busy), .done(done),
    .div_err(div_err), .acc_out(acc_out), .hi_out(hi_out), .cf_of(cf_of)
  );

  function automatic void model(input bit dv, input bit sg, input bit wd,
                                input logic [15:0] a, input logic [15:0] h,
                                input logic [15:0] s,
                                output logic [15:0] ea, output logic [15:0] eh,
                                output logic ef, output logic ee);
    longint av, bv, p, dd, q, r, lo, hi;
    ea = a; eh = h; ef = 1'b0; ee = 1'b0;
    if (!dv) begin
      if (wd) begin
        av = sg ? longint'($signed(a)) : longint'(a);
        bv = sg ? longint'($signed(s)) : longint'(s);
        p = av * bv;
        ea = p[15:0]; eh = p[31:16];
        ef = sg ? (p < -32768 || p > 32767) : (p > 65535);
      end else begin
        av = sg ? longint'($signed(a[7:0])) : longint'(a[7:0]);
        bv = sg ? longint'($signed(s[7:0])) : longint'(s[7:0]);
        p = av * bv;
        ea = p[15:0];
        ef = sg ? (p < -128 || p > 127) : (p > 255);
      end
    end else begin
      if (wd) begin
        dd = sg ? longint'($signed({h, a})) : longint'({h, a});
        bv = sg ? longint'($signed(s)) : longint'(s);
        lo = sg ? -32768 : 0; hi = sg ? 32767 : 65535;
      end else begin
        dd = sg ? longint'($signed(a)) : longint'(a);
        bv = sg ? longint'($signed(s[7:0])) : longint'(s[7:0]);
        lo = sg ? -128 : 0; hi = sg ? 127 : 255;
      end
      if (bv == 0) ee = 1'b1;
      else begin
        q = dd / bv; r = dd % bv;
        if (q < lo || q > hi) ee = 1'b1;
        else if (wd) begin ea = q[15:0]; eh = r[15:0]; end
        else ea = {r[7:0], q[7:0]};
      end
    end
  endfunction

  task automatic run_op(input bit dv, input bit sg, input bit wd,
                        input logic [15:0] a, input logic [15:0] h,
                        input logic [15:0] s);
    logic [15:0] ea, eh;
    logic ef, ee;
    int cyc;
    bit busy_ok;
    string req;
    model(dv, sg, wd, a, h, s, ea, eh, ef, ee);
    req = dv ? (wd ? "R4" : "R3") : (wd ? "R2" : "R1");
    if (sg) req = {req, " R5"};
    if (ee) req = {req, " R6"};
    req = {req, " R7"};
    @(negedge clk);
    op_div = dv; op_signed = sg; op_wide = wd;
    acc_in = a; hi_in = h; src_in = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busy_ok = busy;
    cyc = 0;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    n_chk++;
    if (acc_out !== ea || hi_out !== eh || cf_of !== ef || div_err !== ee) begin
      n_bad++;
      $display("FAIL %s div=%0b sgn=%0b wide=%0b a=%h h=%h s=%h: got acc=%h hi=%h cf=%b err=%b expected acc=%h hi=%h cf=%b err=%b",
               req, dv, sg, wd, a, h, s, acc_out, hi_out, cf_of, div_err, ea, eh, ef, ee);
    end
    n_chk++;
    if (!busy_ok || cyc != (wd ? W : W / 2) + 1) begin
      n_bad++;
      $display("FAIL R8 latency: got %0d busy=%0b expected %0d busy=1",
               cyc, busy_ok, (wd ? W : W / 2) + 1);
    end
  endtask

  initial begin
    #600000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int pulses;
    rst_n = 1'b0; start = 1'b0; op_div = 1'b0; op_signed = 1'b0; op_wide = 1'b0;
    acc_in = '0; hi_in = '0; src_in = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    n_chk++;
    if (acc_out !== 0 || hi_out !== 0 || cf_of !== 0 || done !== 0 || div_err !== 0 || busy !== 0) begin
      n_bad++;
      $display("FAIL R10 reset: got acc=%h hi=%h cf=%b done=%b err=%b busy=%b expected all zero",
               acc_out, hi_out, cf_of, done, div_err, busy);
    end
    rst_n = 1'b1;

    // R1 R5 R7 narrow multiply sweep
    for (int sg = 0; sg < 2; sg++)
      for (int i = 0; i < 16; i++)
        for (int j = 0; j < 16; j++)
          run_op(1'b0, sg[0], 1'b0, {8'(j * 7), 8'(i * 17)}, 16'hA5C3, {8'(i), 8'(j * 29 + 3)});
    // R3 R5 R6 narrow divide sweep (j==0 divides by zero)
    for (int sg = 0; sg < 2; sg++)
      for (int i = 0; i < 24; i++)
        for (int j = 0; j < 16; j++)
          run_op(1'b1, sg[0], 1'b0, 16'(i * 2857 + 5), 16'h5A3C,
                 {8'(i), (j == 0) ? 8'd0 : 8'(j * 17 + 1)});
    // R2 R5 R7 wide multiply sweep
    for (int sg = 0; sg < 2; sg++)
      for (int i = 0; i < 20; i++)
        for (int j = 0; j < 20; j++)
          run_op(1'b0, sg[0], 1'b1, 16'(i * 3449 + 1), 16'h1234, 16'(j * 6079 + 32767));
    // R4 R5 R6 wide divide sweep
    for (int sg = 0; sg < 2; sg++)
      for (int i = 0; i < 20; i++)
        for (int j = 0; j < 20; j++)
          run_op(1'b1, sg[0], 1'b1, 16'(i * 40503), 16'(i * 97 + ((i % 3 == 0) ? 16'hFFF0 : 0)),
                 (j == 19) ? 16'd0 : 16'(j * 3001 + 7));

    // R7 corners
    run_op(1'b0, 1'b1, 1'b0, 16'h0080, 16'h0000, 16'h0080);
    run_op(1'b0, 1'b0, 1'b0, 16'h00FF, 16'h0000, 16'h00FF);
    run_op(1'b0, 1'b1, 1'b0, 16'h00FF, 16'h0000, 16'h0080);
    run_op(1'b0, 1'b1, 1'b1, 16'h8000, 16'h0000, 16'h8000);
    // R5 truncation toward zero, remainder sign
    run_op(1'b1, 1'b1, 1'b0, 16'hFFF9, 16'h0000, 16'h0002);
    run_op(1'b1, 1'b1, 1'b0, 16'h0007, 16'h0000, 16'h00FE);
    run_op(1'b1, 1'b1, 1'b1, 16'hFFF9, 16'hFFFF, 16'h0002);
    // R6 signed range limits
    run_op(1'b1, 1'b1, 1'b0, 16'hFF80, 16'h0000, 16'h00FF);
    run_op(1'b1, 1'b1, 1'b0, 16'hFF80, 16'h0000, 16'h0001);
    run_op(1'b1, 1'b1, 1'b1, 16'h8000, 16'hFFFF, 16'hFFFF);
    run_op(1'b1, 1'b1, 1'b1, 16'h8000, 16'hFFFF, 16'h0001);
    // R4 R6 unsigned range limits
    run_op(1'b1, 1'b0, 1'b1, 16'h0001, 16'hFFFE, 16'hFFFF);
    run_op(1'b1, 1'b0, 1'b1, 16'h0000, 16'hFFFF, 16'hFFFF);
    run_op(1'b1, 1'b0, 1'b0, 16'hFFFF, 16'h0000, 16'h0000);

    // R9 start while busy is ignored
    @(negedge clk);
    op_div = 1'b0; op_signed = 1'b0; op_wide = 1'b0;
    acc_in = 16'h0007; hi_in = 16'h4242; src_in = 16'h0009; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    acc_in = 16'h00FF; src_in = 16'h00FF; op_div = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0; acc_in = 16'h0007; src_in = 16'h0009; op_div = 1'b0;
    pulses = 0;
    for (int k = 0; k < 25; k++) begin
      @(negedge clk);
      if (done) begin
        pulses++;
        n_chk++;
        if (acc_out !== 16'h003F || hi_out !== 16'h4242 || div_err !== 1'b0) begin
          n_bad++;
          $display("FAIL R9 result: got acc=%h hi=%h err=%b expected acc=003f hi=4242 err=0",
                   acc_out, hi_out, div_err);
        end
      end
    end
    n_chk++;
    if (pulses != 1 || busy !== 1'b0) begin
      n_bad++;
      $display("FAIL R9 done pulses: got %0d busy=%b expected 1 busy=0", pulses, busy);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule